// File: doc/BRIEF.md
# Synchronous Serial Port (SPI Master / Slave)

An 8-bit full-duplex serial shift port that can act as the clock-driving end or the clock-following end of an SPI link. A 4-bit mode code in a control register picks the role. As a master, it also picks where the bit clock comes from: one of three fixed divisions of the system clock, half the rate of an external timer pulse, or a divider whose reload value is held in a register. As a slave, the bit clock is taken from the SCK pin. The slave-select pin is either obeyed or ignored, depending on the mode.

Software works the port through four byte-wide registers on a plain read/write bus. Writing the data register loads the transmit shift register. In master mode this write also starts a transfer. Reading the data register returns the last received byte and clears the buffer-full flag. Two sticky error flags record a write made while a byte is still shifting and a byte that arrived while the buffer was still unread. Both flags stay set until software writes 0 to them. Data moves MSB first. The port drives its output on the edge that leaves the idle clock level and samples its input on the edge that returns to idle. The clock-polarity bit sets the idle level.

Top module: `ssp_port`

## Requirements
- R1: The register map is as follows. Address 0 is control: bits [3:0] mode, bit 4 clock polarity, bit 5 enable, bit 6 overflow flag, bit 7 collision flag. Address 1 is data, address 2 is the divider reload, and address 3 is status, with bit 0 as buffer full. In mode 0000 the master SCK period is 4 system clocks, in 0001 it is 16, and in 0010 it is 64.
- R2: In mode 0011 the master SCK level toggles once per external timer pulse, so the SCK period equals two pulse intervals.
- R3: In mode 1010 the master SCK period is 4*(D+1) system clocks, where D is the divider reload. With D = 0 this mode is illegal, and a data write starts no transfer.
- R4: While a master is enabled and idle, SCK sits at the polarity bit: low for 0, high for 1.
- R5: Bytes shift MSB first. The output bit changes on the edge that leaves idle, and the input is sampled on the edge that returns to idle. After eight bits the received byte lands in the data buffer.
- R6: A data write made while a byte is in progress sets the collision flag and is otherwise ignored. The byte in flight is undisturbed. The flag stays set until a control write carries 0 in bit 7, and a 1 there leaves it unchanged.
- R7: In slave mode, a byte that completes while the buffer is full sets the overflow flag. The buffer keeps its old byte, and the new one is dropped. The flag is cleared only by a control write with 0 in bit 6.
- R8: In master mode the overflow flag is never set. A new byte overwrites the buffer even if it was unread.
- R9: The buffer-full bit rises when a received byte enters the buffer and falls only when the data register is read.
- R10: In mode 0100, a high slave-select turns off the data output driver, clears the bit counter so a partial byte is discarded, and makes SCK edges have no effect.
- R11: In mode 0101, bytes are received and sent regardless of the slave-select level.
- R12: With the enable bit at 0, neither SCK nor the data output is driven, and a data write starts no transfer. After reset all registers read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a read of data clears buffer full) |
| addr | input | 2 | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for the addressed register |
| tmr_tick_i | input | 1 | External timer pulse, one clock wide |
| sck_i | input | 1 | Serial clock from the pin (slave) |
| sck_o | output | 1 | Serial clock to the pin (master) |
| sck_oe | output | 1 | Serial clock driver enable |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data driver enable |
| ss_n_i | input | 1 | Slave select, active low |

## Verification
The properties assume that software never writes the data register in the same cycle as a slave clock edge that finishes a byte. They also assume that slave-side pin changes arrive slowly compared with the system clock, so that every SCK level lasts well beyond the synchronizer delay. The bench drives SCK and the slave-select pin with eight system clocks per half period, and it only changes the mode or polarity while the port is disabled and its clock pin already rests at the new idle level. Master transfers run on a loopback of the data output, either direct or inverted, so the expected received byte follows from the written byte alone.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam logic [3:0] MODE_DIV4     = 4'b0000;
    localparam logic [3:0] MODE_DIV16    = 4'b0001;
    localparam logic [3:0] MODE_DIV64    = 4'b0010;
    localparam logic [3:0] MODE_TIMER    = 4'b0011;
    localparam logic [3:0] MODE_SLV_SEL  = 4'b0100;
    localparam logic [3:0] MODE_SLV_FREE = 4'b0101;
    localparam logic [3:0] MODE_RELOAD   = 4'b1010;

    localparam logic [1:0] REG_CTL  = 2'd0;
    localparam logic [1:0] REG_DATA = 2'd1;
    localparam logic [1:0] REG_DIV  = 2'd2;
    localparam logic [1:0] REG_STAT = 2'd3;

    // Packed so that the fields land on control bits 7..0.
    typedef struct packed {
        logic       wcol;
        logic       ovf;
        logic       en;
        logic       pol;
        logic [3:0] mode;
    } ctl_t;

    function automatic logic mode_is_master(input logic [3:0] m);
        return (m == MODE_DIV4) || (m == MODE_DIV16) || (m == MODE_DIV64) ||
               (m == MODE_TIMER) || (m == MODE_RELOAD);
    endfunction

    function automatic logic mode_is_slave(input logic [3:0] m);
        return (m == MODE_SLV_SEL) || (m == MODE_SLV_FREE);
    endfunction

endpackage

// File: rtl/ssp_pinsync.sv
module ssp_pinsync #(
    parameter int         W       = 3,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {STAGES{RST_VAL}};
        else        stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/ssp_clkgen.sv
module ssp_clkgen
    import ssp_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [3:0]       mode,
    input  logic [DIV_W-1:0] reload,
    input  logic             tmr_tick,
    output logic             half_tick
);

    localparam int CNT_W = DIV_W + 2;

    logic [CNT_W-1:0] half_len;
    logic [CNT_W-1:0] rl_ext;
    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign rl_ext = {2'b00, reload};

    // Half a bit period, in system clocks.
    always_comb begin
        case (mode)
            MODE_DIV16:  half_len = CNT_W'(8);
            MODE_DIV64:  half_len = CNT_W'(32);
            MODE_RELOAD: half_len = (rl_ext + CNT_W'(1)) << 1;
            default:     half_len = CNT_W'(2);
        endcase
    end

    always_comb begin
        cnt_d     = cnt_q;
        half_tick = 1'b0;
        if (!run) begin
            cnt_d = '0;
        end else if (mode == MODE_TIMER) begin
            half_tick = tmr_tick;
        end else if (cnt_q == half_len - CNT_W'(1)) begin
            half_tick = 1'b1;
            cnt_d     = '0;
        end else begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/ssp_port.sv
module ssp_port
    import ssp_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              tmr_tick_i,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic              sdo_oe,
    input  logic              ss_n_i
);

    localparam int CNT_W = $clog2(DATA_W) + 1;

    typedef struct packed {
        ctl_t              ctl;
        logic [DIV_W-1:0]  reload;
        logic [DATA_W-1:0] rxbuf;
        logic              full;
        logic [DATA_W-1:0] sr;
        logic [CNT_W-1:0]  bitcnt;
        logic              busy;
        logic              phase;
        logic              sdo;
        logic              sck_prev;
    } st_t;

    st_t st_d, st_q;

    logic [2:0] pins_sync;
    logic       s_sck, s_sdi, s_ss_n;
    logic       half_tick;

    // Plain views of state, also used by the bound checker.
    logic              en_w, pol_w, wcol_w, ovf_w, full_w, busy_w;
    logic              master_w, slave_w, legal_w, ss_hold_w;
    logic [DATA_W-1:0] rxbuf_w;

    assign en_w      = st_q.ctl.en;
    assign pol_w     = st_q.ctl.pol;
    assign wcol_w    = st_q.ctl.wcol;
    assign ovf_w     = st_q.ctl.ovf;
    assign full_w    = st_q.full;
    assign busy_w    = st_q.busy;
    assign rxbuf_w   = st_q.rxbuf;
    assign master_w  = mode_is_master(st_q.ctl.mode);
    assign slave_w   = mode_is_slave(st_q.ctl.mode);
    assign legal_w   = master_w && !((st_q.ctl.mode == MODE_RELOAD) && (st_q.reload == '0));
    assign ss_hold_w = (st_q.ctl.mode == MODE_SLV_SEL) && s_ss_n;

    ssp_pinsync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sck_i, sdi_i, ss_n_i}),
        .dout  (pins_sync)
    );

    assign s_sck  = pins_sync[2];
    assign s_sdi  = pins_sync[1];
    assign s_ss_n = pins_sync[0];

    ssp_clkgen #(
        .DIV_W (DIV_W)
    ) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy_w),
        .mode      (st_q.ctl.mode),
        .reload    (st_q.reload),
        .tmr_tick  (tmr_tick_i),
        .half_tick (half_tick)
    );

    logic              s_leave, s_return;
    logic              do_leave, do_return;
    logic              in_bit;
    logic [DATA_W-1:0] shifted;

    always_comb begin
        s_leave   = (st_q.sck_prev == pol_w) && (s_sck != pol_w);
        s_return  = (st_q.sck_prev != pol_w) && (s_sck == pol_w);
        do_leave  = en_w && ((master_w && busy_w && half_tick && !st_q.phase) ||
                             (slave_w && !ss_hold_w && s_leave));
        do_return = en_w && ((master_w && busy_w && half_tick && st_q.phase) ||
                             (slave_w && !ss_hold_w && s_return));
        in_bit    = master_w ? sdi_i : s_sdi;
        shifted   = {st_q.sr[DATA_W-2:0], in_bit};
    end

    always_comb begin
        st_d          = st_q;
        st_d.sck_prev = s_sck;

        // Reading the data register empties the buffer.
        if (rd_en && addr == REG_DATA) st_d.full = 1'b0;

        if (wr_en && addr == REG_CTL) begin
            st_d.ctl.mode = wdata[3:0];
            st_d.ctl.pol  = wdata[4];
            st_d.ctl.en   = wdata[5];
            st_d.ctl.ovf  = st_q.ctl.ovf  & wdata[6];
            st_d.ctl.wcol = st_q.ctl.wcol & wdata[7];
        end
        if (wr_en && addr == REG_DIV) st_d.reload = wdata[DIV_W-1:0];

        if (do_leave) begin
            st_d.sdo = st_q.sr[DATA_W-1];
            if (master_w) st_d.phase = 1'b1;
        end

        if (do_return) begin
            st_d.sr    = shifted;
            st_d.phase = 1'b0;
            if (st_q.bitcnt == CNT_W'(DATA_W - 1)) begin
                st_d.bitcnt = '0;
                st_d.busy   = 1'b0;
                if (slave_w && st_q.full) begin
                    st_d.ctl.ovf = 1'b1;
                end else begin
                    st_d.rxbuf = shifted;
                    st_d.full  = 1'b1;
                end
            end else begin
                st_d.bitcnt = st_q.bitcnt + CNT_W'(1);
            end
        end

        if (!en_w || !legal_w) begin
            st_d.busy  = 1'b0;
            st_d.phase = 1'b0;
        end
        if (!en_w || ss_hold_w || (!slave_w && !legal_w)) st_d.bitcnt = '0;

        if (wr_en && addr == REG_DATA && en_w) begin
            if (legal_w) begin
                if (busy_w) begin
                    st_d.ctl.wcol = 1'b1;
                end else begin
                    st_d.sr     = wdata;
                    st_d.busy   = 1'b1;
                    st_d.bitcnt = '0;
                    st_d.phase  = 1'b0;
                end
            end else if (slave_w) begin
                if (st_q.bitcnt != '0) st_d.ctl.wcol = 1'b1;
                else                   st_d.sr       = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (addr)
            REG_CTL:  rdata = DATA_W'({wcol_w, ovf_w, en_w, pol_w, st_q.ctl.mode});
            REG_DATA: rdata = rxbuf_w;
            REG_DIV:  rdata = DATA_W'(st_q.reload);
            default:  rdata = DATA_W'(full_w);
        endcase
    end

    assign sck_o  = pol_w ^ st_q.phase;
    assign sck_oe = en_w && master_w;
    assign sdo_o  = st_q.sdo;
    assign sdo_oe = en_w && (master_w || (slave_w && !ss_hold_w));

endmodule

// File: rtl/ssp_port_chk.sv
module ssp_port_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [1:0]        addr,
    input logic [DATA_W-1:0] wdata,
    input logic              en,
    input logic              is_master,
    input logic              busy,
    input logic              pol,
    input logic              sck_o,
    input logic              sck_oe,
    input logic              sdo_oe,
    input logic              ss_hold,
    input logic              wcol,
    input logic              ovf,
    input logic              full,
    input logic [DATA_W-1:0] rxbuf
);

    p_idle_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && is_master && !busy) |-> (sck_o == pol));

    p_wcol_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wcol && !(wr_en && addr == 2'd0 && !wdata[7])) |=> wcol);

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(wr_en && addr == 2'd0 && !wdata[6])) |=> ovf);

    p_ovf_keeps_buf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $stable(rxbuf));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && !ovf) |=> !ovf);

    p_full_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full) |-> $past(rd_en && addr == 2'd1));

    p_ss_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ss_hold) |-> !sdo_oe);

    p_disabled_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!sck_oe && !sdo_oe));

endmodule

bind ssp_port ssp_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .en        (en_w),
    .is_master (master_w),
    .busy      (busy_w),
    .pol       (pol_w),
    .sck_o     (sck_o),
    .sck_oe    (sck_oe),
    .sdo_oe    (sdo_oe),
    .ss_hold   (ss_hold_w),
    .wcol      (wcol_w),
    .ovf       (ovf_w),
    .full      (full_w),
    .rxbuf     (rxbuf_w)
);

// File: tb/test_ssp_port.sv
`timescale 1ns/100ps
module test_ssp_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00, rdata;
    logic       tmr_tick = 1'b0;
    logic       sck_i = 1'b0, sck_o, sck_oe;
    logic       sdi_i, sdo_o, sdo_oe;
    logic       ss_n = 1'b1;
    logic       sdi_drv = 1'b0, loop_inv = 1'b0, slv_tb = 1'b0;
    logic       spol = 1'b0;
    int         tick_period = 0, tcnt = 0;
    int         checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    assign sdi_i = slv_tb ? sdi_drv : (sdo_o ^ loop_inv);

    ssp_port i_ssp_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tmr_tick_i(tmr_tick), .sck_i(sck_i),
        .sck_o(sck_o), .sck_oe(sck_oe), .sdi_i(sdi_i), .sdo_o(sdo_o),
        .sdo_oe(sdo_oe), .ss_n_i(ss_n)
    );

    always @(negedge clk) begin
        if (tick_period > 0 && tcnt >= tick_period - 1) begin
            tcnt <= 0; tmr_tick <= 1'b1;
        end else begin
            tcnt <= tcnt + 1; tmr_tick <= 1'b0;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1; #1; d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; #1; d = rdata;
    endtask

    task automatic wait_full(input string req);
        logic [7:0] s = 8'h00;
        for (int i = 0; i < 3000; i++) begin
            peek(2'd3, s);
            if (s[0]) break;
        end
        chk(s[0], req, s[0], 1);
    endtask

    task automatic measure(input logic p, output int per);
        int   t = 0, e1 = -1;
        logic prev = sck_o;
        per = -1;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk); t++;
            if (prev == p && sck_o != p) begin
                if (e1 < 0) e1 = t;
                else begin per = t - e1; break; end
            end
            prev = sck_o;
        end
    endtask

    task automatic slave_bits(input logic [7:0] mosi, input int nb, output logic [7:0] miso);
        miso = 8'h00;
        for (int i = 0; i < nb; i++) begin
            @(negedge clk); sck_i = ~spol; sdi_drv = mosi[7-i];
            repeat (8) @(negedge clk);
            miso[7-i] = sdo_o; sck_i = spol;
            repeat (8) @(negedge clk);
        end
    endtask

    task automatic slave_setup(input logic p, input logic [3:0] m);
        wr(2'd0, 8'h00);
        spol = p; sck_i = p;
        repeat (6) @(negedge clk);
        wr(2'd0, {2'b00, 1'b1, p, m});
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] r, mi, exp_b;
        int         per, tog;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset values and quiet pins
        peek(2'd0, r); chk(r == 8'h00, "R12 ctl reset", r, 0);
        peek(2'd3, r); chk(r == 8'h00, "R12 status reset", r, 0);
        chk(!sck_oe && !sdo_oe, "R12 pins off at reset", {sck_oe, sdo_oe}, 0);

        // R12: disabled port ignores a data write
        wr(2'd0, 8'h00); wr(2'd1, 8'h55);
        tog = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk); if (sck_oe || sck_o) tog++;
        end
        chk(tog == 0, "R12 no clock when disabled", tog, 0);
        peek(2'd3, r); chk(r[0] == 1'b0, "R12 no byte when disabled", r[0], 0);

        // R4: idle level follows polarity
        wr(2'd0, 8'h30); chk(sck_oe && sck_o == 1'b1, "R4 idle high", sck_o, 1);
        wr(2'd0, 8'h20); chk(sck_oe && sck_o == 1'b0, "R4 idle low", sck_o, 0);

        // R1: fixed divides, both polarities, loopback data
        for (int m = 0; m < 3; m++) begin
            for (int p = 0; p < 2; p++) begin
                loop_inv = 1'b0;
                wr(2'd0, {2'b00, 1'b1, p[0], m[3:0]});
                exp_b = 8'h5C ^ m[7:0] ^ {p[0], 7'd0};
                wr(2'd1, exp_b);
                measure(p[0], per);
                chk(per == (4 << (2 * m)), "R1 sck period", per, 4 << (2 * m));
                wait_full("R9 full after master byte");
                rd(2'd1, r); chk(r == exp_b, "R5 loopback byte", r, exp_b);
            end
        end

        // R3: reload divider sweep
        wr(2'd0, 8'h2A);
        for (int a = 1; a <= 5; a++) begin
            wr(2'd2, a[7:0]);
            wr(2'd1, 8'hC0 | a[7:0]);
            measure(1'b0, per);
            chk(per == 4 * (a + 1), "R3 reload period", per, 4 * (a + 1));
            wait_full("R9 full after reload byte");
            rd(2'd1, r); chk(r == (8'hC0 | a[7:0]), "R3 reload data", r, 8'hC0 | a[7:0]);
        end
        wr(2'd2, 8'h00); wr(2'd1, 8'h99);
        tog = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk); if (sck_o) tog++;
        end
        chk(tog == 0, "R3 reload zero starts nothing", tog, 0);
        peek(2'd3, r); chk(r[0] == 1'b0, "R3 reload zero no byte", r[0], 0);

        // R2: timer-driven clock
        wr(2'd0, 8'h23);
        for (int k = 3; k <= 5; k += 2) begin
            tick_period = k;
            wr(2'd1, 8'hA0 + k[7:0]);
            measure(1'b0, per);
            chk(per == 2 * k, "R2 timer period", per, 2 * k);
            wait_full("R9 full after timer byte");
            rd(2'd1, r); chk(r == 8'hA0 + k[7:0], "R2 timer data", r, 8'hA0 + k[7:0]);
        end
        tick_period = 0;

        // R5 / R9: every byte value, polarity and inversion varied
        for (int v = 0; v < 256; v++) begin
            loop_inv = v[1];
            wr(2'd0, {2'b00, 1'b1, v[0], 4'b0000});
            wr(2'd1, v[7:0]);
            wait_full("R9 full set");
            rd(2'd1, r);
            exp_b = v[7:0] ^ {8{v[1]}};
            chk(r == exp_b, "R5 sweep byte", r, exp_b);
            peek(2'd3, r); chk(r[0] == 1'b0, "R9 full cleared by read", r[0], 0);
        end
        loop_inv = 1'b0;

        // R6: master collision
        wr(2'd0, 8'h22); wr(2'd1, 8'hA5);
        repeat (40) @(negedge clk);
        wr(2'd1, 8'h3C);
        peek(2'd0, r); chk(r[7] == 1'b1, "R6 collision flagged", r[7], 1);
        wait_full("R6 transfer completes");
        rd(2'd1, r); chk(r == 8'hA5, "R6 write ignored", r, 8'hA5);
        wr(2'd0, 8'hA2); peek(2'd0, r); chk(r[7] == 1'b1, "R6 flag sticky", r[7], 1);
        wr(2'd0, 8'h22); peek(2'd0, r); chk(r[7] == 1'b0, "R6 flag cleared", r[7], 0);

        // R8: master never overflows
        wr(2'd0, 8'h20); wr(2'd1, 8'h11);
        wait_full("R8 first byte");
        wr(2'd1, 8'h22);
        repeat (60) @(negedge clk);
        peek(2'd0, r); chk(r[6] == 1'b0, "R8 no overflow", r[6], 0);
        rd(2'd1, r); chk(r == 8'h22, "R8 buffer overwritten", r, 8'h22);

        // R11: slave ignoring select, select held high
        slv_tb = 1'b1; ss_n = 1'b1;
        for (int v = 0; v < 16; v++) begin
            logic [7:0] tx, mo;
            slave_setup(v[0], 4'b0101);
            tx = (v[7:0] * 8'd17) ^ 8'h96;
            mo = v[7:0] * 8'd13 + 8'd7;
            wr(2'd1, tx);
            slave_bits(mo, 8, mi);
            repeat (8) @(negedge clk);
            chk(mi == tx, "R5 slave sends MSB first", mi, tx);
            peek(2'd3, r); chk(r[0] == 1'b1, "R9 slave full", r[0], 1);
            rd(2'd1, r); chk(r == mo, "R11 slave receive", r, mo);
        end

        // R7: slave overflow keeps the old byte
        slave_setup(1'b0, 4'b0101);
        wr(2'd1, 8'h00);
        slave_bits(8'h3C, 8, mi);
        slave_bits(8'hC3, 8, mi);
        repeat (8) @(negedge clk);
        peek(2'd0, r); chk(r[6] == 1'b1, "R7 overflow set", r[6], 1);
        rd(2'd1, r); chk(r == 8'h3C, "R7 old byte kept", r, 8'h3C);
        wr(2'd0, 8'h65); peek(2'd0, r); chk(r[6] == 1'b1, "R7 flag sticky", r[6], 1);
        wr(2'd0, 8'h25); peek(2'd0, r); chk(r[6] == 1'b0, "R7 flag cleared", r[6], 0);

        // R6: slave collision mid-byte
        wr(2'd1, 8'h00);
        slave_bits(8'hF0, 3, mi);
        wr(2'd1, 8'hFF);
        peek(2'd0, r); chk(r[7] == 1'b1, "R6 slave collision", r[7], 1);

        // R10: select abort and ignore
        ss_n = 1'b0;
        slave_setup(1'b0, 4'b0100);
        repeat (6) @(negedge clk);
        chk(sdo_oe == 1'b1, "R10 driven when selected", sdo_oe, 1);
        rd(2'd1, r);
        wr(2'd1, 8'h5A);
        slave_bits(8'hFF, 4, mi);
        ss_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(sdo_oe == 1'b0, "R10 released when deselected", sdo_oe, 0);
        peek(2'd3, r); chk(r[0] == 1'b0, "R10 partial byte dropped", r[0], 0);
        ss_n = 1'b0;
        repeat (6) @(negedge clk);
        wr(2'd1, 8'h81);
        slave_bits(8'h4B, 8, mi);
        repeat (8) @(negedge clk);
        chk(mi == 8'h81, "R10 fresh byte sent", mi, 8'h81);
        rd(2'd1, r); chk(r == 8'h4B, "R10 counter restarted", r, 8'h4B);
        ss_n = 1'b1;
        repeat (6) @(negedge clk);
        slave_bits(8'h77, 8, mi);
        repeat (8) @(negedge clk);
        peek(2'd3, r); chk(r[0] == 1'b0, "R10 edges ignored", r[0], 0);

        // R12: disable releases pins
        wr(2'd0, 8'h05);
        chk(!sck_oe && !sdo_oe, "R12 pins off after disable", {sck_oe, sdo_oe}, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule